// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers a vector of external interrupt lines into a single interrupt request for a processor. Each channel has its own enable, its own choice between level and edge triggering, and its own choice of active polarity. A trigger that fires on an enabled channel is held in a per-channel capture buffer. A trigger on a disabled channel is discarded and leaves no trace.

When the controller is idle and any buffered request exists, it selects the lowest-numbered buffered channel and latches that channel's ID. It then drives the CPU interrupt line. The latched ID stays fixed until software writes the source register. That write acknowledges the interrupt, clears the buffer of the reported channel only, and lets the next buffered request be presented one cycle later.

Software reaches the controller through a small word-addressed register bus with an address, write data, a write strobe and combinational read data. The number of channels is a parameter from 1 to 32. The channels occupy the low end of the input vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable, trigger-kind and polarity registers read zero, the source register reads zero, and `cpu_irq` is low.
- R2: Byte offset 0x0 holds the channel enables, 0x8 the trigger kind (bit 1 = edge, 0 = level) and 0xC the polarity (bit 1 = high level or rising edge, 0 = low level or falling edge). Each reads back the written value, with bits at or above NUM_CH reading zero. An access whose address bits 1:0 are not zero writes nothing and reads zero.
- R3: A level-triggered channel is captured in every cycle its input sits at the selected level, for both high and low polarity. An input still held after an acknowledge raises the interrupt again.
- R4: An edge-triggered channel is captured once per transition in the selected direction, either rising or falling. A steady input and a transition in the other direction capture nothing.
- R5: A trigger that fires while its channel is disabled is discarded. Enabling the channel afterwards raises no interrupt from it.
- R6: If more than one request is buffered when a source is chosen, the lowest channel number is reported.
- R7: Reading offset 0x4 returns bit 31 = interrupt active and bits 4:0 = reported channel ID. Bits 30:5 read zero, and the whole word reads zero while no interrupt is active.
- R8: A write of any data to offset 0x4 while an interrupt is active drops `cpu_irq` at that clock edge and clears only the reported channel's buffer. A remaining buffered request is presented on the following edge.
- R9: The reported ID does not change while the interrupt is active, even if a higher-priority request arrives, until it is acknowledged.
- R10: An input change sampled at clock edge N is buffered at edge N and raises `cpu_irq` at edge N+1.
- R11: Inputs at positions NUM_CH and above never cause an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acts at the rising clock edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_in | input | 32 | External interrupt lines, channel n on bit n |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The block has two register stages between an input and the output. A trigger is buffered at the edge that samples it, and `cpu_irq` rises at the next edge. An acknowledge drops `cpu_irq` at its own edge, and a waiting request returns one edge later. A newly written enable takes one further edge before it can buffer anything. The bench drives on falling edges and counts these edges exactly. It checks that `cpu_irq` is still low one edge early and high on the due edge, and it reads the source register half a cycle after setting the address. Where a requirement says nothing happens, the bench waits at least one edge beyond the due point before checking that the output is still idle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned MAX_CH  = 32;
  localparam int unsigned ID_W    = 5;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned SEL_LSB = 2;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_SOURCE = 2'd1,
    SEL_KIND   = 2'd2,
    SEL_POL    = 2'd3
  } reg_sel_e;

  // Trigger evaluation for one channel.
  function automatic logic trig_hit(input logic is_edge, input logic hi_active,
                                    input logic cur, input logic prev,
                                    input logic hist_ok);
    logic lvl;
    logic edg;
    lvl = hi_active ? cur : ~cur;
    edg = hi_active ? (cur & ~prev) : (~cur & prev);
    return is_edge ? (edg & hist_ok) : lvl;
  endfunction

  // Index of the lowest set bit; zero when none is set.
  function automatic logic [ID_W-1:0] first_set(input logic [MAX_CH-1:0] v);
    logic [ID_W-1:0] id;
    id = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) id = ID_W'(i);
    end
    return id;
  endfunction

endpackage

// File: rtl/irq_trig_unit.sv
module irq_trig_unit
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] line_in,
  input  logic [NUM_CH-1:0] edge_sel,
  input  logic [NUM_CH-1:0] hi_sel,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] fire
);

  logic [NUM_CH-1:0] prev_q;
  logic              hist_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      hist_ok_q <= 1'b0;
    end else begin
      prev_q    <= line_in;
      hist_ok_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign fire[g] = ch_en[g] &
                     trig_hit(edge_sel[g], hi_sel[g], line_in[g], prev_q[g], hist_ok_q);
  end

endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic              ack,
  output logic [NUM_CH-1:0] pend,
  output logic              active,
  output logic [ID_W-1:0]   src_id
);

  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] clr_mask;
  logic [MAX_CH-1:0] pend_wide;
  logic              active_q;
  logic [ID_W-1:0]   src_q;
  logic              take_ack;

  assign take_ack  = ack & active_q;
  assign pend_wide = MAX_CH'(pend_q);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    assign clr_mask[g] = take_ack & (src_q == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      src_q    <= '0;
    end else if (take_ack) begin
      active_q <= 1'b0;
      src_q    <= '0;
    end else if (!active_q && (|pend_q)) begin
      active_q <= 1'b1;
      src_q    <= first_set(pend_wide);
    end
  end

  assign pend   = pend_q;
  assign active = active_q;
  assign src_id = src_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              active,
  input  logic [ID_W-1:0]   src_id,
  output logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] edge_sel,
  output logic [NUM_CH-1:0] hi_sel,
  output logic              ack,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned PAD_W = DATA_W - 1 - ID_W;

  reg_sel_e          sel;
  logic              aligned;
  logic              wr_hit;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] kind_q;
  logic [NUM_CH-1:0] pol_q;

  assign sel     = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
  assign aligned = (bus_addr[SEL_LSB-1:0] == '0);
  assign wr_hit  = bus_we & aligned;
  assign ack     = wr_hit & (sel == SEL_SOURCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      kind_q <= '0;
      pol_q  <= '0;
    end else if (wr_hit) begin
      unique case (sel)
        SEL_ENABLE: en_q   <= bus_wdata[NUM_CH-1:0];
        SEL_KIND:   kind_q <= bus_wdata[NUM_CH-1:0];
        SEL_POL:    pol_q  <= bus_wdata[NUM_CH-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_ENABLE: bus_rdata = DATA_W'(en_q);
        SEL_SOURCE: bus_rdata = active ? {1'b1, {PAD_W{1'b0}}, src_id} : '0;
        SEL_KIND:   bus_rdata = DATA_W'(kind_q);
        SEL_POL:    bus_rdata = DATA_W'(pol_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign ch_en    = en_q;
  assign edge_sel = kind_q;
  assign hi_sel   = pol_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       irq_in,
  output logic              cpu_irq
);

  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] edge_sel;
  logic [NUM_CH-1:0] hi_sel;
  logic [NUM_CH-1:0] fire_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic              active;
  logic [ID_W-1:0]   src_id;
  logic              ack_evt;

  irq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .active    (active),
    .src_id    (src_id),
    .ch_en     (ch_en),
    .edge_sel  (edge_sel),
    .hi_sel    (hi_sel),
    .ack       (ack_evt),
    .bus_rdata (bus_rdata)
  );

  irq_trig_unit #(.NUM_CH(NUM_CH)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (irq_in[NUM_CH-1:0]),
    .edge_sel (edge_sel),
    .hi_sel   (hi_sel),
    .ch_en    (ch_en),
    .fire     (fire_vec)
  );

  irq_pend_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire_vec),
    .ack    (ack_evt),
    .pend   (pend_vec),
    .active (active),
    .src_id (src_id)
  );

  assign cpu_irq = active;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_irq,
  input logic [3:0]        bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [ID_W-1:0]   src_id,
  input logic              ack_evt
);

  logic [MAX_CH-1:0] pend_wide;
  logic [MAX_CH-1:0] below_mask;
  logic              pend_any;

  assign pend_wide  = MAX_CH'(pend_vec);
  assign below_mask = (MAX_CH'(1) << src_id) - MAX_CH'(1);
  assign pend_any   = |pend_vec;

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && cpu_irq) |=> !cpu_irq);

  // R9
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !ack_evt) |=> (cpu_irq && $stable(src_id)));

  // R10
  raise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(pend_any));

  // R6
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> (($past(pend_wide) & below_mask) == '0));

  // R7
  src_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h4) |-> ((bus_rdata[30:5] == '0) && (bus_rdata[31] == cpu_irq)));

  // R11
  src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (32'(src_id) < NUM_CH));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_irq   (cpu_irq),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pend_vec  (pend_vec),
  .src_id    (src_id),
  .ack_evt   (ack_evt)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;

  irq_prio_ctrl #(.NUM_CH(NCH)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .cpu_irq   (cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    logic [31:0] d;
    irq_in = '0; bus_we = 1'b0; rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1", "cpu_irq after reset", 32'(cpu_irq), 0);
    rd(4'h0, d); chk("R1", "enable after reset", d, 0);
    rd(4'h4, d); chk("R1", "source after reset", d, 0);
    rd(4'h8, d); chk("R1", "kind after reset", d, 0);
    rd(4'hC, d); chk("R1", "polarity after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2", "enable masked readback", d, 32'h00FF_FFFF);
    rd(4'h8, d); chk("R2", "kind masked readback", d, 32'h00FF_FFFF);
    wr(4'hC, 32'h5A5A_5A5A);
    rd(4'hC, d); chk("R2", "polarity readback", d, 32'h005A_5A5A);
    wr(4'h9, 32'h0);
    rd(4'h8, d); chk("R2", "unaligned write ignored", d, 32'h00FF_FFFF);
    rd(4'hA, d); chk("R2", "unaligned read zero", d, 0);
    // R11: all channels rising-edge enabled, pulse only the unused upper lines
    wr(4'hC, 32'hFFFF_FFFF);
    irq_in = 32'hFF00_0000;
    step(4);
    chk("R11", "upper inputs ignored", 32'(cpu_irq), 0);
    rd(4'h4, d); chk("R11", "source idle", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    wr(4'hC, 32'h8);
    wr(4'h0, 32'h8);
    step(2);
    chk("R3", "high level idle while low", 32'(cpu_irq), 0);
    irq_in[3] = 1'b1;
    step(1);
    chk("R10", "not raised one edge after input", 32'(cpu_irq), 0);
    step(1);
    chk("R10", "raised two edges after input", 32'(cpu_irq), 1);
    rd(4'h4, d); chk("R7", "source word ch3", d, 32'h8000_0003);
    wr(4'h4, 32'h1234_5678);
    chk("R8", "ack drops irq", 32'(cpu_irq), 0);
    step(1);
    chk("R3", "held level recaptured", 32'(cpu_irq), 1);
    irq_in[3] = 1'b0;
    wr(4'h4, 32'h0);
    step(3);
    chk("R3", "released level stays idle", 32'(cpu_irq), 0);
    wr(4'h0, 32'h1);
    step(2);
    chk("R3", "low level ch0 captured", 32'(cpu_irq), 1);
    rd(4'h4, d); chk("R3", "low level source", d, 32'h8000_0000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    wr(4'h8, 32'h60);
    wr(4'hC, 32'h20);
    irq_in[6] = 1'b1;
    step(2);
    wr(4'h0, 32'h60);
    step(3);
    chk("R4", "steady lines no capture", 32'(cpu_irq), 0);
    irq_in[5] = 1'b1;
    step(2);
    chk("R4", "rising edge captured", 32'(cpu_irq), 1);
    rd(4'h4, d); chk("R4", "rising source", d, 32'h8000_0005);
    wr(4'h4, 32'h0);
    step(3);
    chk("R4", "held high no recapture", 32'(cpu_irq), 0);
    irq_in[6] = 1'b0;
    step(2);
    chk("R4", "falling edge captured", 32'(cpu_irq), 1);
    rd(4'h4, d); chk("R4", "falling source", d, 32'h8000_0006);
    wr(4'h4, 32'h0);
    irq_in[5] = 1'b0;
    step(3);
    chk("R4", "wrong direction ignored", 32'(cpu_irq), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(4'h8, 32'h80);
    wr(4'hC, 32'h80);
    irq_in[7] = 1'b1;
    step(2);
    irq_in[7] = 1'b0;
    step(2);
    wr(4'h0, 32'h80);
    step(4);
    chk("R5", "disabled trigger discarded", 32'(cpu_irq), 0);
    irq_in[7] = 1'b1;
    step(2);
    chk("R5", "enabled trigger captured", 32'(cpu_irq), 1);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    do_reset();
    wr(4'hC, 32'h206);
    irq_in[2] = 1'b1;
    irq_in[9] = 1'b1;
    wr(4'h0, 32'h206);
    step(2);
    chk("R6", "irq with two requests", 32'(cpu_irq), 1);
    rd(4'h4, d); chk("R6", "lowest channel wins", d, 32'h8000_0002);
    irq_in[2] = 1'b0;
    wr(4'h4, 32'h0);
    step(1);
    rd(4'h4, d); chk("R8", "next request one edge later", d, 32'h8000_0009);
    irq_in[1] = 1'b1;
    step(3);
    rd(4'h4, d); chk("R9", "source held despite higher request", d, 32'h8000_0009);
    irq_in[9] = 1'b0;
    wr(4'h4, 32'h0);
    step(1);
    rd(4'h4, d); chk("R8", "higher request after ack", d, 32'h8000_0001);
    irq_in[1] = 1'b0;
    wr(4'h4, 32'h0);
    step(3);
    rd(4'h4, d); chk("R7", "idle source word zero", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1);
    t_regs();
    t_level();
    t_edge();
    t_disabled();
    t_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule